// File: doc/BRIEF.md
# YCbCr 4:2:2 Chroma Subsampler

This block turns a 4:4:4 pixel stream into a 4:2:2 stream. Each input beat carries one pixel with three components: luma, blue-difference chroma and red-difference chroma. In 4:2:2 encoding, every output beat carries the pixel's luma plus one chroma sample. The two chroma kinds alternate within each pixel pair. When the encoding select is set to 4:4:4, the block forwards all three components unchanged. This covers RGB, YCbCr 4:4:4 and luma-only traffic.

Two selects shape the 4:2:2 output:

- **Subsampling select.** Either the chroma of the second pixel of each pair is discarded, or the two chroma samples of the pair are averaged, rounding half up.
- **Order select.** Either Cb or Cr goes out on the first pixel of a pair.

A line-start flag on the input beat restarts the pairing. A line with an odd pixel count ends in a lone pixel, which carries its own chroma. The three selects are sampled as pixels leave the first pipeline stage, so they must be held steady while a line is in flight.

Both stream edges use valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high.

Back-pressure rules:

- While `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` is low.
- While frozen, the output holds its value and nothing is lost.
- `in_ready` does not depend on `in_valid`.

Top module: `ycc422_subsampler`

## Requirements
- R1: With `cfg_enc`=0, each pixel leaves with `out_luma`=Y, `out_chroma`=Cb and `out_aux`=Cr, all unchanged.
- R2: A pixel accepted in cycle n appears on the output in cycle n+2 when `out_ready` stays high. There is exactly one output beat per input beat, in order, and `out_luma` equals the input luma in both encodings.
- R3: In 4:2:2 with `cfg_avg`=0 (drop), the first pixel of a pair carries its own first-ordered chroma. The second pixel carries the first pixel's second-ordered chroma, so the second pixel's own chroma is discarded.
- R4: In 4:2:2 with `cfg_avg`=1 (average):
  - The first pixel of a pair carries (a+b+1)>>1 of the first-ordered chroma of both pixels.
  - The second pixel carries the same rounded mean of their second-ordered chroma.
- R5: `cfg_cr_first`=0 makes Cb the first-ordered chroma and Cr the second. `cfg_cr_first`=1 swaps them.
- R6: An accepted beat with `in_sol`=1 is always the first pixel of a pair.
- R7: A first pixel with no partner carries its own first-ordered chroma alone, in both modes. A first pixel has no partner when the next advancing cycle brings no beat or brings a line start.
- R8: In 4:2:2 encoding `out_aux` is zero.
- R9: While `out_valid`=1 and `out_ready`=0:
  - `in_ready` is 0.
  - All outputs hold their values on the next cycle.
  - Once released, every pixel emerges in order.
- R10: After reset `out_valid` is 0 and `in_ready` is 1, and the first pixel accepted is the first of a pair even without a line start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enc | input | 1 | 0: 4:4:4 pass-through, 1: 4:2:2 |
| cfg_avg | input | 1 | 0: drop chroma, 1: average pair chroma |
| cfg_cr_first | input | 1 | 0: Cb first in pair, 1: Cr first |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_y | input | W | Luma (or first component) |
| in_cb | input | W | Cb (or second component) |
| in_cr | input | W | Cr (or third component) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_luma | output | W | Luma |
| out_chroma | output | W | Subsampled chroma, or second component in 4:4:4 |
| out_aux | output | W | Third component in 4:4:4, zero in 4:2:2 |

## Verification
The bench covers the following corner cases:

- **Rounding at the range extremes.** Extreme values such as 0 with full scale catch an averager that truncates instead of rounding, or that wraps because it lacks a carry bit.
- **Pair restart.** A line start in the middle of a pair, and a gap after a first pixel, expose a design that pairs across line starts or waits forever for a partner. Either fault shows up as a wrong chroma value on the lone pixel.
- **Swapped order.** Both chroma orders are applied under drop and under average, which catches swapped chroma kinds or a second pixel that keeps its own chroma.
- **Back-pressure.** A stall held for several cycles catches a pipeline that keeps accepting input, or that lets the output change under back-pressure.

// File: rtl/ycc422_pkg.sv
package ycc422_pkg;

  typedef enum logic {
    ENC_PASS = 1'b0,
    ENC_422  = 1'b1
  } enc_e;

  typedef enum logic {
    SUB_DROP = 1'b0,
    SUB_AVG  = 1'b1
  } sub_e;

  typedef enum logic {
    ORD_CB_FIRST = 1'b0,
    ORD_CR_FIRST = 1'b1
  } ord_e;

  localparam int unsigned NUM_LANES = 2;  // first- and second-ordered chroma

endpackage

// File: rtl/ycc422_avg.sv
module ycc422_avg #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int unsigned SW = W + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(a) + SW'(b) + SW'(1);
    y   = W'(sum >> 1);
  end
endmodule

// File: rtl/ycc422_stage.sv
module ycc422_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         in_valid,
  input  logic         in_sol,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_cb,
  input  logic [W-1:0] in_cr,
  output logic         s1_valid,
  output logic         s1_second,
  output logic [W-1:0] s1_y,
  output logic [W-1:0] s1_cb,
  output logic [W-1:0] s1_cr,
  output logic [W-1:0] mate_cb,
  output logic [W-1:0] mate_cr
);
  logic last_second;
  logic nxt_second;

  always_comb nxt_second = in_sol ? 1'b0 : ~last_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_second <= 1'b1;
      s1_valid    <= 1'b0;
      s1_second   <= 1'b0;
      s1_y        <= '0;
      s1_cb       <= '0;
      s1_cr       <= '0;
      mate_cb     <= '0;
      mate_cr     <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        last_second <= nxt_second;
        s1_second   <= nxt_second;
        s1_y        <= in_y;
        s1_cb       <= in_cb;
        s1_cr       <= in_cr;
      end
      if (s1_valid) begin
        mate_cb <= s1_cb;
        mate_cr <= s1_cr;
      end
    end
  end
endmodule

// File: rtl/ycc422_chroma_sel.sv
module ycc422_chroma_sel
  import ycc422_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  sub_e         mode,
  input  ord_e         order,
  input  logic         s1_second,
  input  logic [W-1:0] s1_cb,
  input  logic [W-1:0] s1_cr,
  input  logic         partner_ok,
  input  logic [W-1:0] nxt_cb,
  input  logic [W-1:0] nxt_cr,
  input  logic [W-1:0] mate_cb,
  input  logic [W-1:0] mate_cr,
  output logic [W-1:0] chroma
);
  // lane 0: first-ordered chroma of the pair, lane 1: second-ordered
  logic [W-1:0] own_c   [NUM_LANES];
  logic [W-1:0] other_c [NUM_LANES];
  logic [W-1:0] mean_c  [NUM_LANES];

  always_comb begin
    if (order == ORD_CB_FIRST) begin
      own_c[0]   = s1_cb;
      other_c[0] = nxt_cb;
      own_c[1]   = s1_cr;
      other_c[1] = mate_cr;
    end else begin
      own_c[0]   = s1_cr;
      other_c[0] = nxt_cr;
      own_c[1]   = s1_cb;
      other_c[1] = mate_cb;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ycc422_avg #(.W(W)) u_avg (
      .a(own_c[g]),
      .b(other_c[g]),
      .y(mean_c[g])
    );
  end

  always_comb begin
    if (!s1_second) begin
      chroma = (mode == SUB_AVG && partner_ok) ? mean_c[0] : own_c[0];
    end else begin
      chroma = (mode == SUB_AVG) ? mean_c[1] : other_c[1];
    end
  end
endmodule

// File: rtl/ycc422_subsampler.sv
module ycc422_subsampler
  import ycc422_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_enc,
  input  logic         cfg_avg,
  input  logic         cfg_cr_first,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_sol,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_cb,
  input  logic [W-1:0] in_cr,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_luma,
  output logic [W-1:0] out_chroma,
  output logic [W-1:0] out_aux
);
  logic         adv;
  logic         s1_valid, s1_second;
  logic [W-1:0] s1_y, s1_cb, s1_cr, mate_cb, mate_cr;
  logic         partner_ok;
  logic [W-1:0] sel_c;
  enc_e         enc;

  always_comb begin
    adv        = !out_valid || out_ready;
    in_ready   = adv;
    partner_ok = in_valid && !in_sol;
    enc        = enc_e'(cfg_enc);
  end

  ycc422_stage #(.W(W)) u_stage (
    .clk(clk), .rst(rst), .adv(adv),
    .in_valid(in_valid), .in_sol(in_sol),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .s1_valid(s1_valid), .s1_second(s1_second),
    .s1_y(s1_y), .s1_cb(s1_cb), .s1_cr(s1_cr),
    .mate_cb(mate_cb), .mate_cr(mate_cr)
  );

  ycc422_chroma_sel #(.W(W)) u_sel (
    .mode(sub_e'(cfg_avg)), .order(ord_e'(cfg_cr_first)),
    .s1_second(s1_second), .s1_cb(s1_cb), .s1_cr(s1_cr),
    .partner_ok(partner_ok), .nxt_cb(in_cb), .nxt_cr(in_cr),
    .mate_cb(mate_cb), .mate_cr(mate_cr),
    .chroma(sel_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_luma   <= '0;
      out_chroma <= '0;
      out_aux    <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_luma  <= s1_y;
      if (enc == ENC_PASS) begin
        out_chroma <= s1_cb;
        out_aux    <= s1_cr;
      end else begin
        out_chroma <= sel_c;
        out_aux    <= '0;
      end
    end
  end
endmodule

// File: rtl/ycc422_checker.sv
module ycc422_checker #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_enc,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_y,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_luma,
  input logic [W-1:0] out_chroma,
  input logic [W-1:0] out_aux
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_luma) &&
                                $stable(out_chroma) && $stable(out_aux));

  // R9
  blocked_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R8
  aux_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && cfg_enc && $stable(cfg_enc) && $past(in_ready) |-> out_aux == '0);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R2
  luma_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready && !rst, 2) && $past(in_ready) |->
      out_valid && out_luma == $past(in_y, 2));
endmodule

bind ycc422_subsampler ycc422_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cfg_enc(cfg_enc),
  .in_valid(in_valid), .in_ready(in_ready), .in_y(in_y),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_luma(out_luma), .out_chroma(out_chroma), .out_aux(out_aux)
);

// File: tb/ycc422_subsampler_bench.sv
module ycc422_subsampler_bench;
  localparam int W  = 10;
  localparam int NV = 9;
  localparam int NE = 128;

  // {sol, y, cb, cr, expected chroma}; average mode, Cb first
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 10'd100, 10'd10,   10'd20,   10'd12},
    {1'b0, 10'd101, 10'd13,   10'd30,   10'd25},
    {1'b0, 10'd102, 10'd0,    10'd1023, 10'd512},
    {1'b0, 10'd103, 10'd1023, 10'd0,    10'd512},
    {1'b1, 10'd104, 10'd7,    10'd8,    10'd8},
    {1'b0, 10'd105, 10'd9,    10'd10,   10'd9},
    {1'b0, 10'd106, 10'd500,  10'd600,  10'd500},
    {1'b1, 10'd107, 10'd1023, 10'd1023, 10'd1023},
    {1'b0, 10'd108, 10'd1023, 10'd1023, 10'd1023}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enc = 1'b1, cfg_avg = 1'b1, cfg_cr_first = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_luma, out_chroma, out_aux;

  int n_chk = 0, n_fail = 0, n_exp = 0, n_got = 0;
  bit done = 0;
  logic [W-1:0] ey [NE];
  logic [W-1:0] ec [NE];
  logic [W-1:0] ea [NE];
  string        et [NE];

  always #5 clk = ~clk;

  ycc422_subsampler #(.W(W)) u_ycc422_subsampler (
    .clk(clk), .rst(rst), .cfg_enc(cfg_enc), .cfg_avg(cfg_avg),
    .cfg_cr_first(cfg_cr_first), .in_valid(in_valid), .in_ready(in_ready),
    .in_sol(in_sol), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_ready(out_ready), .out_luma(out_luma),
    .out_chroma(out_chroma), .out_aux(out_aux)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_px(input int y, input int c, input int a, input string tag);
    ey[n_exp] = W'(y); ec[n_exp] = W'(c); ea[n_exp] = W'(a); et[n_exp] = tag;
    n_exp++;
  endtask

  // inputs change 2 ns after a rising edge; acceptance is judged at the falling edge
  task automatic send(input bit sol, input int y, input int cb, input int cr);
    bit acc;
    in_valid = 1'b1; in_sol = sol; in_y = W'(y); in_cb = W'(cb); in_cr = W'(cr);
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #2;
    end while (!acc);
    in_valid = 1'b0; in_sol = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && n_got < n_exp; i++) @(posedge clk);
    #2;
    check(n_got == n_exp, "R2 beat count", n_got, n_exp);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (n_got < n_exp) begin
        check(out_luma == ey[n_got], {et[n_got], " luma"}, int'(out_luma), int'(ey[n_got]));
        check(out_chroma == ec[n_got], {et[n_got], " chroma"}, int'(out_chroma), int'(ec[n_got]));
        check(out_aux == ea[n_got], {et[n_got], " aux"}, int'(out_aux), int'(ea[n_got]));
      end else begin
        check(1'b0, "R2 extra output beat", n_got, n_exp);
      end
      n_got++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #2;

    // table walk: R4 average, R6 line restarts, R7 lone pixel, R8 aux, R10 first pair
    for (int i = 0; i < NV; i++)
      expect_px(int'(VEC[i][39:30]), int'(VEC[i][9:0]), 0, "R4,R6,R7,R8,R10 table");
    for (int i = 0; i < NV; i++)
      send(VEC[i][40], int'(VEC[i][39:30]), int'(VEC[i][29:20]), int'(VEC[i][19:10]));
    drain();

    // R3 drop, Cb first
    cfg_avg = 1'b0; cfg_cr_first = 1'b0;
    expect_px(1, 40, 0, "R3"); expect_px(2, 50, 0, "R3");
    send(1, 1, 40, 50); send(0, 2, 60, 70);
    drain();

    // R5 drop, Cr first
    cfg_cr_first = 1'b1;
    expect_px(1, 50, 0, "R5 drop"); expect_px(2, 40, 0, "R5 drop");
    send(1, 1, 40, 50); send(0, 2, 60, 70);
    drain();

    // R5 with R4: average, Cr first
    cfg_avg = 1'b1;
    expect_px(3, 10, 0, "R5,R4 avg"); expect_px(4, 4, 0, "R5,R4 avg");
    send(1, 3, 3, 9); send(0, 4, 4, 10);
    drain();

    // R1 pass-through
    cfg_enc = 1'b0; cfg_cr_first = 1'b0;
    expect_px(5, 111, 222, "R1"); expect_px(6, 333, 444, "R1");
    send(1, 5, 111, 222); send(0, 6, 333, 444);
    drain();

    // R7 gap after a first pixel: lone chroma, mate still averaged by the second
    cfg_enc = 1'b1;
    expect_px(9, 100, 0, "R7 gap"); expect_px(10, 300, 0, "R7 gap");
    send(1, 9, 100, 200);
    @(posedge clk); #2;
    send(0, 10, 300, 400);
    drain();

    // R2 latency of a single lone pixel (drop mode)
    cfg_avg = 1'b0;
    expect_px(7, 11, 0, "R2,R7 single");
    send(1, 7, 11, 12);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 not yet valid one cycle after accept", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 valid two cycles after input", int'(out_valid), 1);
    drain();

    // R9 back-pressure
    cfg_avg = 1'b1;
    expect_px(11, 21, 0, "R9"); expect_px(12, 32, 0, "R9"); expect_px(13, 5, 0, "R9");
    out_ready = 1'b0;
    fork
      begin
        send(1, 11, 20, 30); send(0, 12, 22, 33); send(0, 13, 5, 6);
      end
      begin
        repeat (4) @(negedge clk);
        check(in_ready == 1'b0, "R9 in_ready low under stall", int'(in_ready), 0);
        check(out_valid == 1'b1, "R9 output valid under stall", int'(out_valid), 1);
        held = out_luma;
        repeat (3) @(negedge clk);
        check(out_luma == held && out_valid, "R9 output held", int'(out_luma), int'(held));
        @(posedge clk); #2;
        out_ready = 1'b1;
      end
    join
    drain();

    finish_run();
  end
endmodule